// File: doc/BRIEF.md
# Core Register File with Role-Bound Registers

This block is the architectural register store of a small single-cycle core. Every register index has a fixed role. Index 0 is a constant zero. Index 1 is the program counter and index 2 is the stack pointer. Index 3 returns this core's identifier, which is set by a parameter, so that cores sharing memory can tell each other apart. Indices 4 to 8 are five general-purpose registers for user data. The decoder uses writes to index 0 as its idle encoding, so such writes must leave every register as it was.

The block has two asynchronous (combinational) read ports and one synchronous write port. It also has two dedicated update paths, one for the program counter and one for the stack pointer, which the fetch and stack logic drive directly. An active-low asynchronous reset clears the program counter and the user registers. The same reset loads the stack pointer with the highest word address of the local data memory, because the stack grows downward from that address.

Top module: `core_regfile`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, PC reads 0, SP reads DMEM_WORDS-1 (127 by default) and user registers 4..8 read 0.
- R2: Index 0 always reads 0 on both read ports. A write to index 0 changes no register.
- R3: Index 3 always reads CORE_ID. A write to index 3 is discarded.
- R4: A write with wr_en=1 to index 4..8 (user registers A..E) is visible on both read ports from the next cycle onward.
- R5: Reads are combinational. In the cycle a write is presented, a read of the same index returns the previous value.
- R6: pc_we=1 loads pc_next into the program counter (index 1) at the clock edge. pc_out and reads of index 1 show it from the next cycle. With no update, PC holds its value.
- R7: sp_we=1 loads sp_next into the stack pointer (index 2) at the clock edge. sp_out and reads of index 2 show it from the next cycle. With no update, SP holds its value.
- R8: When the general write port targets index 1 or 2 in the same cycle as the matching dedicated update, the general write port's data is stored.
- R9: Indices 9..15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | ADDR_W | Read port A index |
| rd_data_a | output | DATA_W | Read port A data |
| rd_addr_b | input | ADDR_W | Read port B index |
| rd_data_b | output | DATA_W | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_addr | input | ADDR_W | General write index |
| wr_data | input | DATA_W | General write data |
| pc_we | input | 1 | Dedicated program counter update enable |
| pc_next | input | DATA_W | Dedicated program counter value |
| sp_we | input | 1 | Dedicated stack pointer update enable |
| sp_next | input | DATA_W | Dedicated stack pointer value |
| pc_out | output | DATA_W | Current program counter |
| sp_out | output | DATA_W | Current stack pointer |

## Verification
Read data is due in the same cycle as the address, with zero delay. Register contents, including the program counter and stack pointer, change exactly one clock edge after a write or update. The bench drives inputs just after a falling edge and compares all outputs a quarter period later, still before the next rising edge. So every read sees the pending write's old value, and every update is checked one cycle after it is presented. The reference model commits its state only on the rising edge.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
   localparam int IDX_ZERO  = 0;
   localparam int IDX_PC    = 1;
   localparam int IDX_SP    = 2;
   localparam int IDX_ID    = 3;
   localparam int IDX_USER0 = 4;

   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_PORT = 2'd1,
      SRC_DED  = 2'd2
   } load_src_e;
endpackage

// File: rtl/regfile_cell.sv
module regfile_cell #(
   parameter int          DATA_W  = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/regfile_wr_arb.sv
module regfile_wr_arb
   import regfile_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int NUM_USER = 5
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                pc_we,
   input  logic [DATA_W-1:0]   pc_next,
   input  logic                sp_we,
   input  logic [DATA_W-1:0]   sp_next,
   output logic                pc_load,
   output logic [DATA_W-1:0]   pc_val,
   output logic                sp_load,
   output logic [DATA_W-1:0]   sp_val,
   output logic [NUM_USER-1:0] user_load
);
   load_src_e pc_src, sp_src;
   logic      port_pc, port_sp;

   assign port_pc = wr_en && (wr_addr == ADDR_W'(IDX_PC));
   assign port_sp = wr_en && (wr_addr == ADDR_W'(IDX_SP));

   // general port outranks the dedicated paths
   always_comb begin
      pc_src = port_pc ? SRC_PORT : (pc_we ? SRC_DED : SRC_HOLD);
      sp_src = port_sp ? SRC_PORT : (sp_we ? SRC_DED : SRC_HOLD);
   end

   assign pc_load = (pc_src != SRC_HOLD);
   assign sp_load = (sp_src != SRC_HOLD);
   assign pc_val  = (pc_src == SRC_PORT) ? wr_data : pc_next;
   assign sp_val  = (sp_src == SRC_PORT) ? wr_data : sp_next;

   // zero, ID and unmapped indices have no decode term: writes vanish
   for (genvar i = 0; i < NUM_USER; i++) begin : g_user_dec
      assign user_load[i] = wr_en && (wr_addr == ADDR_W'(IDX_USER0 + i));
   end
endmodule

// File: rtl/regfile_rd_port.sv
module regfile_rd_port
   import regfile_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 4,
   parameter int          NUM_USER = 5,
   parameter int unsigned CORE_ID  = 0
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               pc_q,
   input  logic [DATA_W-1:0]               sp_q,
   input  logic [NUM_USER-1:0][DATA_W-1:0] user_q,
   output logic [DATA_W-1:0]               data
);
   localparam logic [DATA_W-1:0] ID_VAL = DATA_W'(CORE_ID);

   always_comb begin
      data = '0;
      if (addr == ADDR_W'(IDX_PC))
         data = pc_q;
      else if (addr == ADDR_W'(IDX_SP))
         data = sp_q;
      else if (addr == ADDR_W'(IDX_ID))
         data = ID_VAL;
      for (int i = 0; i < NUM_USER; i++) begin
         if (addr == ADDR_W'(IDX_USER0 + i))
            data = user_q[i];
      end
   end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
   import regfile_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 4,
   parameter int          NUM_USER   = 5,
   parameter int          DMEM_WORDS = 128,
   parameter int unsigned CORE_ID    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pc_we,
   input  logic [DATA_W-1:0] pc_next,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] sp_next,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] sp_out
);
   localparam int                NUM_RD  = 2;
   localparam int                NUM_IDX = IDX_USER0 + NUM_USER;
   localparam logic [DATA_W-1:0] SP_RST  = DATA_W'(DMEM_WORDS - 1);

   if (NUM_IDX > (1 << ADDR_W)) begin : g_bad_addr
      $error("core_regfile: ADDR_W too narrow for the register roles");
   end
   if (DMEM_WORDS < 1 || $clog2(DMEM_WORDS) > DATA_W) begin : g_bad_dmem
      $error("core_regfile: DMEM_WORDS out of range for DATA_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("core_regfile: DATA_W must be positive");
   end

   logic                        pc_load, sp_load;
   logic [DATA_W-1:0]           pc_val, sp_val, pc_q, sp_q;
   logic [NUM_USER-1:0]         user_load;
   logic [NUM_USER-1:0][DATA_W-1:0] user_q;

   regfile_wr_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_USER(NUM_USER)) u_arb (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pc_we    (pc_we),
      .pc_next  (pc_next),
      .sp_we    (sp_we),
      .sp_next  (sp_next),
      .pc_load  (pc_load),
      .pc_val   (pc_val),
      .sp_load  (sp_load),
      .sp_val   (sp_val),
      .user_load(user_load)
   );

   regfile_cell #(.DATA_W(DATA_W), .RST_VAL('0)) u_pc (
      .clk(clk), .rst_n(rst_n), .load(pc_load), .d(pc_val), .q(pc_q)
   );

   regfile_cell #(.DATA_W(DATA_W), .RST_VAL(SP_RST)) u_sp (
      .clk(clk), .rst_n(rst_n), .load(sp_load), .d(sp_val), .q(sp_q)
   );

   for (genvar u = 0; u < NUM_USER; u++) begin : g_user
      regfile_cell #(.DATA_W(DATA_W), .RST_VAL('0)) u_cell (
         .clk(clk), .rst_n(rst_n), .load(user_load[u]), .d(wr_data), .q(user_q[u])
      );
   end

   logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_v;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data_v;

   assign rd_addr_v[0] = rd_addr_a;
   assign rd_addr_v[1] = rd_addr_b;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      regfile_rd_port #(
         .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_USER(NUM_USER), .CORE_ID(CORE_ID)
      ) u_port (
         .addr  (rd_addr_v[p]),
         .pc_q  (pc_q),
         .sp_q  (sp_q),
         .user_q(user_q),
         .data  (rd_data_v[p])
      );
   end

   assign rd_data_a = rd_data_v[0];
   assign rd_data_b = rd_data_v[1];
   assign pc_out    = pc_q;
   assign sp_out    = sp_q;
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk #(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 4,
   parameter int          DMEM_WORDS = 128,
   parameter int unsigned CORE_ID    = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic [DATA_W-1:0] rd_data_b,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              pc_we,
   input logic [DATA_W-1:0] pc_next,
   input logic              sp_we,
   input logic [DATA_W-1:0] sp_next,
   input logic [DATA_W-1:0] pc_out,
   input logic [DATA_W-1:0] sp_out
);
   localparam logic [DATA_W-1:0] SP_RST = DATA_W'(DMEM_WORDS - 1);
   localparam logic [DATA_W-1:0] ID_VAL = DATA_W'(CORE_ID);

   logic first_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_cyc <= 1'b1;
      else        first_cyc <= 1'b0;
   end

   logic port_pc, port_sp;
   assign port_pc = wr_en && (wr_addr == ADDR_W'(1));
   assign port_sp = wr_en && (wr_addr == ADDR_W'(2));

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_cyc |-> (pc_out == '0 && sp_out == SP_RST));
   // R2
   zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_addr_a == '0) |-> (rd_data_a == '0)) and ((rd_addr_b == '0) |-> (rd_data_b == '0)));
   // R3
   id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_addr_a == ADDR_W'(3)) |-> (rd_data_a == ID_VAL)) and
      ((rd_addr_b == ADDR_W'(3)) |-> (rd_data_b == ID_VAL)));
   // R6
   pc_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && !port_pc) |=> (pc_out == $past(pc_next)));
   // R6
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_we && !port_pc) |=> $stable(pc_out));
   // R7
   sp_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we && !port_sp) |=> (sp_out == $past(sp_next)));
   // R7
   sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_we && !port_sp) |=> $stable(sp_out));
   // R8
   pc_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_pc |=> (pc_out == $past(wr_data)));
   // R8
   sp_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_sp |=> (sp_out == $past(wr_data)));
endmodule

bind core_regfile regfile_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DMEM_WORDS(DMEM_WORDS), .CORE_ID(CORE_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
   .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .pc_we(pc_we), .pc_next(pc_next), .sp_we(sp_we), .sp_next(sp_next),
   .pc_out(pc_out), .sp_out(sp_out)
);

// File: tb/sim_core_regfile.sv
`timescale 1ns/1ps
module sim_core_regfile;
   localparam int          DW      = 32;
   localparam int          AW      = 4;
   localparam int unsigned ID      = 32'h5A;
   localparam int          WORDS   = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
   logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0, pc_next = '0, sp_next = '0;
   logic [DW-1:0] pc_out, sp_out;
   logic          wr_en = 1'b0, pc_we = 1'b0, sp_we = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   core_regfile #(.DATA_W(DW), .ADDR_W(AW), .NUM_USER(5), .DMEM_WORDS(WORDS), .CORE_ID(ID)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pc_we(pc_we), .pc_next(pc_next), .sp_we(sp_we), .sp_next(sp_next),
      .pc_out(pc_out), .sp_out(sp_out)
   );

   // behavioural reference: one integer slot per index
   logic [DW-1:0] ref_reg [16];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) ref_reg[i] = '0;
         ref_reg[2] = WORDS - 1;
      end else begin
         if (wr_en && wr_addr == 1)  ref_reg[1] = wr_data;
         else if (pc_we)             ref_reg[1] = pc_next;
         if (wr_en && wr_addr == 2)  ref_reg[2] = wr_data;
         else if (sp_we)             ref_reg[2] = sp_next;
         if (wr_en && wr_addr >= 4 && wr_addr <= 8) ref_reg[wr_addr] = wr_data;
      end
   end

   function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] a);
      if (a == 3) return DW'(ID);
      if (a == 0 || a > 8) return '0;
      return ref_reg[a];
   endfunction

   function automatic string tag_of(input logic [AW-1:0] a);
      if (a == 0) return "R2";
      if (a == 3) return "R3";
      if (a > 8)  return "R9";
      if (wr_en && wr_addr == a) return "R5";
      if (a == 1) return "R6";
      if (a == 2) return "R7";
      return "R4";
   endfunction

   task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string pc_tag, input string sp_tag);
      check(tag_of(rd_addr_a), "rd_data_a", rd_data_a, ref_read(rd_addr_a));
      check(tag_of(rd_addr_b), "rd_data_b", rd_data_b, ref_read(rd_addr_b));
      check(pc_tag, "pc_out", pc_out, ref_reg[1]);
      check(sp_tag, "sp_out", sp_out, ref_reg[2]);
   endtask

   // drive after a falling edge, compare a quarter period later
   task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic pw, input logic [DW-1:0] pn,
                      input logic sw, input logic [DW-1:0] sn,
                      input logic [AW-1:0] ra, input logic [AW-1:0] rb);
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      pc_we = pw; pc_next = pn; sp_we = sw; sp_next = sn;
      rd_addr_a = ra; rd_addr_b = rb;
      #5;
      compare_all((we && wa == 1 && pw) ? "R8" : "R6",
                  (we && wa == 2 && sw) ? "R8" : "R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      rd_addr_a = 4'd2; rd_addr_b = 4'd8;
      #5;
      check("R1", "pc_out in reset", pc_out, '0);
      check("R1", "sp_out in reset", sp_out, 32'd127);
      check("R1", "user E in reset", rd_data_b, '0);
      @(negedge clk); rst_n = 1'b1;
      #5;
      check("R1", "sp after release", sp_out, 32'd127);
      check("R1", "pc after release", pc_out, '0);
      // R4 user writes, then read back
      for (int i = 4; i <= 8; i++)
         cyc(1, AW'(i), 32'hA000 + i, 0, 0, 0, 0, AW'(i), AW'(i));
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd4, 4'd8);
      // R2 idle write to zero
      cyc(1, 4'd0, 32'hDEAD, 0, 0, 0, 0, 4'd0, 4'd0);
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd0, 4'd5);
      // R3 write to ID ignored
      cyc(1, 4'd3, 32'hBEEF, 0, 0, 0, 0, 4'd3, 4'd3);
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd3, 4'd6);
      // R9 unmapped index
      cyc(1, 4'd12, 32'h1234, 0, 0, 0, 0, 4'd12, 4'd15);
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd12, 4'd9);
      // R6 / R7 dedicated updates
      cyc(0, 0, 0, 1, 32'h40, 1, 32'd126, 4'd1, 4'd2);
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd1, 4'd2);
      // R8 collisions
      cyc(1, 4'd1, 32'h77, 1, 32'h99, 0, 0, 4'd1, 4'd2);
      cyc(1, 4'd2, 32'h55, 0, 0, 1, 32'h11, 4'd1, 4'd2);
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd1, 4'd2);
      // R5 same-cycle read of a written index
      cyc(1, 4'd6, 32'hF00D, 0, 0, 0, 0, 4'd6, 4'd6);
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd6, 4'd6);
      // mixed traffic
      for (int k = 0; k < 2000; k++)
         cyc(1'($urandom), 4'($urandom), $urandom, 1'($urandom), $urandom,
             1'($urandom), $urandom, 4'($urandom), 4'($urandom));
      // R1 reset again mid-run
      @(negedge clk); rst_n = 1'b0;
      #5;
      check("R1", "sp after re-reset", sp_out, 32'd127);
      check("R1", "pc after re-reset", pc_out, '0);
      @(negedge clk); rst_n = 1'b1;
      cyc(0, 0, 0, 0, 0, 0, 0, 4'd7, 4'd2);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule